// File: doc/BRIEF.md
# Cascadable Fall-Through FIFO

This block is a first-in first-out buffer of 64 words of 9 bits, built as a chain of word stages. Each stage holds one word and a valid bit. A word written at the input moves forward one stage per clock until it reaches the last stage, so it appears at the output without any read request. When the output word is read, the empty slot moves backward one stage per clock until it reaches the input.

The input side has a shift-in strobe and an input-ready flag. The output side has a shift-out strobe, an output-ready flag, and an output-enable that forces the data bus to zero while it is low. The ready flags also serve as the transfer handshake between instances. Two instances chain with no glue logic to hold 128 words: the upstream output-ready drives the downstream shift-in, the downstream input-ready drives the upstream shift-out, and the upstream data output (enable tied high) feeds the downstream data input.

Reset is synchronous and active high.

Top module: `ripple_fifo`

## Requirements
- R1: After a synchronous reset, `in_ready` is 1, `out_ready` is 0 and `dout` is 0.
- R2: A word written into an empty instance raises `out_ready` on the DEPTH-th rising edge, counting the edge that accepts the word. In a chain of two instances this is the 2*DEPTH-th edge.
- R3: Words leave in the order they were accepted, with no loss or duplication. A chain of two holds 2*DEPTH words, and the upstream `in_ready` stays 0 once all stages are full and no read occurs.
- R4: A `shift_in` while `in_ready` is 0 stores nothing.
- R5: A `shift_out` while `out_ready` is 0 removes nothing.
- R6: On the clock after a read (`shift_out` and `out_ready` both 1), `out_ready` is 0. With `shift_out` held high, `out_ready` therefore appears as single-cycle pulses.
- R7: While `out_ready` is 1 and `shift_out` is 0, `out_ready` stays 1 and `dout` keeps its value.
- R8: `dout` equals the word in the last stage when `oe` is 1 and that stage is valid, and is 0 otherwise.
- R9: After one read from a full chain of two, the upstream `in_ready` rises 2*DEPTH-1 edges after the read edge, once the freed slot has moved back to the first stage.
- R10: In every cycle, each instance's stored word count changes by exactly (accepted writes) minus (reads), so a chain handshake moves exactly one word across the boundary.
- R11: `in_ready` is 1 exactly when the first stage is empty. After a write into an empty instance it is 0 for one cycle and then 1 again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| shift_in | input | 1 | Write strobe, taken when `in_ready` is 1 |
| din | input | W (9) | Word to write |
| in_ready | output | 1 | First stage is empty |
| shift_out | input | 1 | Read strobe, taken when `out_ready` is 1 |
| out_ready | output | 1 | Last stage holds a word |
| oe | input | 1 | Output enable; `dout` is 0 while low |
| dout | output | W (9) | Word in the last stage |

## Verification
Two functions can act in the same clock cycle: a write into the first stage and a read from the last stage. The same happens at the chain boundary, where one handshake is the downstream write and the upstream read at once. The bench chains two instances and drives independent random write and read strobes over thousands of cycles, so writes and reads often fall together, both at the outer ports and at the internal boundary. Each read is checked against a bench queue of accepted words, and the per-instance word-count property checks that a coinciding write and read leave the count unchanged.

// File: rtl/ripple_fifo_pkg.sv
package ripple_fifo_pkg;

    localparam int WORD_W_DEF = 9;
    localparam int DEPTH_DEF  = 64;

    // action a single stage takes on the next clock edge
    typedef enum logic [1:0] {
        SLOT_HOLD  = 2'd0,
        SLOT_LOAD  = 2'd1,
        SLOT_DRAIN = 2'd2
    } slot_act_e;

    // an empty slot loads when offered a word; a full slot drains when taken
    function automatic slot_act_e slot_action(input logic full,
                                              input logic offer,
                                              input logic take);
        if (!full && offer)
            return SLOT_LOAD;
        if (full && take)
            return SLOT_DRAIN;
        return SLOT_HOLD;
    endfunction

    // a handshake fires when a strobe meets its ready flag
    function automatic logic fires(input logic strobe, input logic ready);
        return strobe && ready;
    endfunction

endpackage

// File: rtl/ripple_fifo_stage.sv
module ripple_fifo_stage
    import ripple_fifo_pkg::*;
#(
    parameter int W = WORD_W_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         offer,
    input  logic [W-1:0] d_in,
    input  logic         take,
    output logic         full,
    output logic [W-1:0] q
);

    slot_act_e act;

    always_comb act = slot_action(full, offer, take);

    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
        end else begin
            case (act)
                SLOT_LOAD:  full <= 1'b1;
                SLOT_DRAIN: full <= 1'b0;
                default:    full <= full;
            endcase
        end
    end

    // payload needs no reset: it is only seen through the valid bit
    always_ff @(posedge clk) begin
        if (act == SLOT_LOAD)
            q <= d_in;
    end

endmodule

// File: rtl/ripple_fifo_outport.sv
module ripple_fifo_outport
    import ripple_fifo_pkg::*;
#(
    parameter int W = WORD_W_DEF
) (
    input  logic         tail_full,
    input  logic [W-1:0] tail_q,
    input  logic         shift_out,
    input  logic         oe,
    output logic         out_ready,
    output logic         pop,
    output logic [W-1:0] dout
);

    always_comb begin
        out_ready = tail_full;
        pop       = fires(shift_out, tail_full);
        dout      = (oe && tail_full) ? tail_q : '0;
    end

endmodule

// File: rtl/ripple_fifo.sv
module ripple_fifo
    import ripple_fifo_pkg::*;
#(
    parameter int W     = WORD_W_DEF,
    parameter int DEPTH = DEPTH_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_in,
    input  logic [W-1:0] din,
    output logic         in_ready,
    input  logic         shift_out,
    output logic         out_ready,
    input  logic         oe,
    output logic [W-1:0] dout
);

    localparam int LAST = DEPTH - 1;

    logic [DEPTH-1:0] stage_vld;
    logic [DEPTH-1:0] stage_offer;
    logic [DEPTH-1:0] stage_take;
    logic [W-1:0]     stage_q [DEPTH];
    logic [W-1:0]     stage_d [DEPTH];
    logic             pop;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        // feed side: the head takes the write port, others the previous stage
        if (i == 0) begin : g_head
            assign stage_offer[i] = shift_in;
            assign stage_d[i]     = din;
        end else begin : g_body
            assign stage_offer[i] = stage_vld[i-1];
            assign stage_d[i]     = stage_q[i-1];
        end

        // drain side: the tail empties on a read, others when the next is free
        if (i == LAST) begin : g_tail
            assign stage_take[i] = pop;
        end else begin : g_mid
            assign stage_take[i] = stage_vld[i] && !stage_vld[i+1];
        end

        ripple_fifo_stage #(.W(W)) u_stage (
            .clk   (clk),
            .rst   (rst),
            .offer (stage_offer[i]),
            .d_in  (stage_d[i]),
            .take  (stage_take[i]),
            .full  (stage_vld[i]),
            .q     (stage_q[i])
        );
    end

    assign in_ready = !stage_vld[0];

    ripple_fifo_outport #(.W(W)) u_out (
        .tail_full (stage_vld[LAST]),
        .tail_q    (stage_q[LAST]),
        .shift_out (shift_out),
        .oe        (oe),
        .out_ready (out_ready),
        .pop       (pop),
        .dout      (dout)
    );

endmodule

// File: rtl/ripple_fifo_chk.sv
module ripple_fifo_chk #(
    parameter int W     = 9,
    parameter int DEPTH = 64
) (
    input logic             clk,
    input logic             rst,
    input logic             shift_in,
    input logic             in_ready,
    input logic             shift_out,
    input logic             out_ready,
    input logic             oe,
    input logic [W-1:0]     dout,
    input logic [DEPTH-1:0] vld
);

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (in_ready && !out_ready && dout == '0))
        else $error("reset state wrong"); // R1

    AST_SHIFT_IN_GATED: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(!in_ready)) |-> ($countones(vld) <= $past($countones(vld))))
        else $error("refused write changed contents"); // R4

    AST_SHIFT_OUT_GATED: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(!out_ready)) |-> ($countones(vld) >= $past($countones(vld))))
        else $error("refused read changed contents"); // R5

    AST_POP_GAP: assert property (@(posedge clk) disable iff (rst)
        (out_ready && shift_out) |=> !out_ready)
        else $error("output ready not dropped after read"); // R6

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (out_ready && !shift_out) |=> (out_ready && (dout == $past(dout) || oe != $past(oe))))
        else $error("output word moved without read"); // R7

    AST_OE_MUTE: assert property (@(posedge clk) disable iff (rst)
        (!oe || !out_ready) |-> dout == '0)
        else $error("data bus not muted"); // R8

    AST_WORD_CONSERVE: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ($countones(vld) == $past($countones(vld))
                         + ($past(shift_in && in_ready) ? 1 : 0)
                         - ($past(shift_out && out_ready) ? 1 : 0)))
        else $error("word count not conserved"); // R10

    AST_HEAD_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (in_ready && shift_in) |=> !in_ready)
        else $error("head stage not filled by write"); // R11

endmodule

bind ripple_fifo ripple_fifo_chk #(.W(W), .DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .shift_in  (shift_in),
    .in_ready  (in_ready),
    .shift_out (shift_out),
    .out_ready (out_ready),
    .oe        (oe),
    .dout      (dout),
    .vld       (stage_vld)
);

// File: tb/ripple_fifo_test.sv
module ripple_fifo_test;

    localparam int W          = 9;
    localparam int DEPTH      = 64;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 100000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         si  = 1'b0;
    logic [W-1:0] din = '0;
    logic         so  = 1'b0;
    logic         oe  = 1'b1;

    logic         a_in_ready, a_out_ready, b_in_ready, b_out_ready;
    logic [W-1:0] a_dout, b_dout;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 1'b0;
    logic [W-1:0] model[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    ripple_fifo #(.W(W), .DEPTH(DEPTH)) uut (
        .clk(clk), .rst(rst), .shift_in(si), .din(din), .in_ready(a_in_ready),
        .shift_out(b_in_ready), .out_ready(a_out_ready), .oe(1'b1), .dout(a_dout)
    );

    ripple_fifo #(.W(W), .DEPTH(DEPTH)) uut_dn (
        .clk(clk), .rst(rst), .shift_in(a_out_ready), .din(a_dout), .in_ready(b_in_ready),
        .shift_out(so), .out_ready(b_out_ready), .oe(oe), .dout(b_dout)
    );

    function automatic int fall_edges(input int depth, input int n_inst);
        return depth * n_inst;
    endfunction

    function automatic int bubble_edges(input int depth, input int n_inst);
        return depth * n_inst - 1;
    endfunction

    function automatic logic [W-1:0] gen_word();
        return W'($urandom);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // called at a falling edge; drives inputs, scores handshakes, ends at next falling edge
    task automatic step(input logic s_in, input logic [W-1:0] d, input logic s_out, input logic o_en);
        bit popped;
        popped = 1'b0;
        si = s_in; din = d; so = s_out; oe = o_en;
        #1;
        if (s_in && a_in_ready)
            model.push_back(d);
        if (s_out && b_out_ready) begin
            popped = 1'b1;
            if (model.size() == 0)
                check(1'b0, "R3 read with nothing stored", int'(b_dout), -1);
            else
                check(b_dout == model[0], "R3 order", int'(b_dout), int'(model[0]));
            if (model.size() != 0)
                void'(model.pop_front());
        end
        if (!o_en)
            check(b_dout == '0, "R8 oe low mutes bus", int'(b_dout), 0);
        @(posedge clk);
        @(negedge clk);
        if (popped)
            check(b_out_ready == 1'b0, "R6 gap after read", int'(b_out_ready), 0);
    endtask

    task automatic idle();
        step(1'b0, '0, 1'b0, 1'b1);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] w;
        int edges;
        int guard;
        void'($urandom(32'h00C0FFEE));

        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check(a_in_ready == 1'b1, "R1 in_ready after reset", int'(a_in_ready), 1);
        check(b_out_ready == 1'b0, "R1 out_ready after reset", int'(b_out_ready), 0);
        check(b_dout == '0, "R1 dout after reset", int'(b_dout), 0);

        // fall-through of one word through both instances
        w = 9'h1A5;
        step(1'b1, w, 1'b0, 1'b1);
        edges = 1;
        check(a_in_ready == 1'b0, "R11 head busy after write", int'(a_in_ready), 0);
        idle(); edges++;
        check(a_in_ready == 1'b1, "R11 head free after advance", int'(a_in_ready), 1);
        while (edges < fall_edges(DEPTH, 2) - 1) begin
            idle(); edges++;
        end
        check(b_out_ready == 1'b0, "R2 not ready one edge early", int'(b_out_ready), 0);
        idle(); edges++;
        check(b_out_ready == 1'b1, "R2 ready at 2*DEPTH edges", int'(b_out_ready), 1);
        check(b_dout == w, "R2 word at output", int'(b_dout), int'(w));

        repeat (5) idle();
        check(b_out_ready == 1'b1, "R7 ready held", int'(b_out_ready), 1);
        check(b_dout == w, "R7 word held", int'(b_dout), int'(w));

        step(1'b0, '0, 1'b0, 1'b0);
        check(b_out_ready == 1'b1, "R8 oe low keeps word", int'(b_out_ready), 1);
        step(1'b0, '0, 1'b1, 1'b1);
        check(b_dout == '0, "R8 empty tail mutes bus", int'(b_dout), 0);
        step(1'b0, '0, 1'b1, 1'b1);
        check(model.size() == 0, "R5 read while not ready ignored", model.size(), 0);

        // fill the chain with random writes, strobing also while not ready
        guard = 0;
        while (model.size() < 2 * DEPTH && guard < 5000) begin
            step(($urandom % 4) != 0, gen_word(), 1'b0, 1'b1);
            guard++;
        end
        repeat (400) idle();
        check(a_in_ready == 1'b0, "R3 full chain refuses", int'(a_in_ready), 0);
        check(b_out_ready == 1'b1, "R3 full chain output ready", int'(b_out_ready), 1);
        check(model.size() == 2 * DEPTH, "R3 capacity", model.size(), 2 * DEPTH);
        repeat (10) step(1'b1, 9'h0FF, 1'b0, 1'b1);   // R4: ignored, shown at drain

        // bubble back after one read
        step(1'b0, '0, 1'b1, 1'b1);
        edges = 1;
        while (edges < bubble_edges(DEPTH, 2)) begin
            idle(); edges++;
        end
        check(a_in_ready == 1'b0, "R9 slot not yet at head", int'(a_in_ready), 0);
        idle();
        check(a_in_ready == 1'b1, "R9 slot reached head", int'(a_in_ready), 1);

        // concurrent random writes and reads, R10 across the boundary
        for (int k = 0; k < 4000; k++) begin
            logic rd;
            rd = ($urandom % 2) == 1;
            step(($urandom % 2) == 1, gen_word(), rd, rd ? 1'b1 : (($urandom % 4) != 0));
        end

        // drain with read held high
        guard = 0;
        while (model.size() != 0 && guard < 5000) begin
            step(1'b0, '0, 1'b1, 1'b1);
            guard++;
        end
        repeat (300) step(1'b0, '0, 1'b1, 1'b1);
        check(model.size() == 0, "R10 all words delivered", model.size(), 0);
        check(b_out_ready == 1'b0, "R4 no stray word stored", int'(b_out_ready), 0);
        check(a_in_ready == 1'b1, "R3 empty chain accepts", int'(a_in_ready), 1);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule